// File: doc/BRIEF.md
# Pin-Addressed I2C Control and Fault-Status Target

This block is an I2C target that holds one 8-bit register. The upper six bits are control settings. A controller writes them over the bus, and each one also drives a dedicated parallel output pin. The lower two bits are read-only. They show the live state of two fault inputs: an over-temperature flag and an overload flag. A controller can read the whole register back as many times as it likes in one transaction. It acknowledges each byte to get another one, and it sends a NACK to end the read.

The 7-bit bus address has one free bit, and a strap input sets that bit, so two of these blocks can share one bus. A power-good input gates the whole function. While power-good is low, the target is deaf to the bus and never pulls SDA. The register is also forced to zero, which keeps the power-enable output low. Once power-good rises, normal operation starts.

SCL and SDA are synchronised to the system clock. SDA is modelled as open drain: the block raises `sda_oe_o` to pull the line low and otherwise leaves it to the pull-up.

Top module: `lnbc_i2c_target`

## Requirements
- R1: The target answers address 7'b0001000 when `addr_sel_i` is 0 and 7'b0001001 when it is 1. It does not acknowledge the other address of the pair.
- R2: A write is START, then the matching address with R/W = 0, then one data byte. The target ACKs both bytes, and data bits 7..2 are then driven on the control outputs: bit 7 `cur_lim_mode_o`, bit 6 `cur_sel_o`, bit 5 `tone_en_o`, bit 4 `line_comp_o`, bit 3 `volt_sel_o`, bit 2 `pwr_en_o`.
- R3: After the matching address with R/W = 1 is ACKed, the target shifts one register byte onto SDA, most significant bit first, over the next eight SCL clocks.
- R4: On the ninth clock of a read byte, a controller ACK (SDA low) makes the target send another byte. A NACK (SDA high) ends the read, and SDA stays released from then on.
- R5: Read bits 7..2 equal the values stored by the most recent accepted write.
- R6: Read bit 1 is the over-temperature input and read bit 0 is the overload input. The values written to these two bit positions have no effect.
- R7: While `pwr_good_i` is low, `sda_oe_o` stays low, no bus traffic is acknowledged, and all six control outputs are 0.
- R8: After `pwr_good_i` rises, a write is acknowledged and takes effect.
- R9: A non-matching address gets no ACK. The target then ignores every bit until the next START, so a following data byte is neither ACKed nor stored.
- R10: A START or STOP in the middle of a transfer aborts it. A partly received data byte is discarded, and a repeated START begins a new address phase.
- R11: The fault bits are captured when a read byte starts to be shifted out. A fault change during the byte shows up only in the next byte.
- R12: After `rst`, the control outputs are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| addr_sel_i | input | 1 | Strap that sets the address LSB |
| pwr_good_i | input | 1 | Supply-good indication; low holds the block silent and cleared |
| fault_temp_i | input | 1 | Over-temperature fault flag |
| fault_ovl_i | input | 1 | Overload fault flag |
| cur_lim_mode_o | output | 1 | Control bit 7 |
| cur_sel_o | output | 1 | Control bit 6 |
| tone_en_o | output | 1 | Control bit 5 |
| line_comp_o | output | 1 | Control bit 4 |
| volt_sel_o | output | 1 | Control bit 3 |
| pwr_en_o | output | 1 | Control bit 2, power enable |

## Verification
The assertions check, on every cycle, the rules that hold whatever the bus traffic is. An unpowered target never drives SDA and holds its register at zero. The register changes only on a write strobe. SDA is released during the controller's acknowledge slot. A START always re-enters the address phase. A mismatched address returns the target to idle. The transmit byte stays frozen between SCL falling edges. Other behaviour shows only as sequences at the pins, so only the directed scenarios can confirm it. These scenarios cover the pin-selected address pair, the byte order and read-only bits seen by a controller, continued reads after ACK, the freezing of fault bits in the middle of a byte, and aborts by STOP or repeated START.

// File: rtl/lnbc_pkg.sv
package lnbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/lnbc_sync.sv
module lnbc_sync #(
  parameter int              WIDTH  = 1,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lnbc_ctrl_reg.sv
module lnbc_ctrl_reg #(
  parameter int CTL_W = 6,
  parameter int FLT_W = 2,
  localparam int REG_W = CTL_W + FLT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [FLT_W-1:0] flt_s,
  output logic [CTL_W-1:0] ctl_q,
  output logic [REG_W-1:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst || !pwr_good) ctl_q <= '0;
    else if (wr_en)       ctl_q <= wr_data[REG_W-1:FLT_W];
  end

  assign rd_byte = {ctl_q, flt_s};

  // R7: unpowered register is cleared
  assert_reg_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (ctl_q == '0));
  // R5: contents change only through a write strobe
  assert_reg_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && !wr_en) |=> $stable(ctl_q));
endmodule

// File: rtl/lnbc_bus_fsm.sv
module lnbc_bus_fsm
  import lnbc_pkg::*;
#(
  parameter int              ADDR_W    = 7,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b0001000,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_byte,
  output logic              sda_oe
);
  tgt_state_t        state;
  logic              scl_d, sda_d, rw_q, ack_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_q, tx_q;

  logic start_det, stop_det, scl_rise, scl_fall, addr_hit, byte_full;
  logic [ADDR_W-1:0] my_addr;

  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign scl_rise  = scl_s && !scl_d;
  assign scl_fall  = !scl_s && scl_d;
  assign my_addr   = {ADDR_BASE[ADDR_W-1:1], addr_sel};
  assign addr_hit  = (rx_q[DATA_W-1:DATA_W-ADDR_W] == my_addr);
  assign byte_full = (cnt == CNT_W'(DATA_W));
  assign wr_byte   = rx_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      state  <= ST_IDLE;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      cnt    <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              rx_q <= {rx_q[DATA_W-2:0], sda_s};
              cnt  <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (state == ST_WDATA) begin
                state  <= ST_WDATA_ACK;
                sda_oe <= 1'b1;
                wr_en  <= 1'b1;
              end else if (addr_hit) begin
                state  <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rw_q   <= rx_q[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                tx_q   <= rd_byte;
                sda_oe <= !rd_byte[DATA_W-1];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDATA;
              end
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                sda_oe <= !tx_q[DATA_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              ack_q <= !sda_s;
            end else if (scl_fall) begin
              if (ack_q) begin
                cnt    <= '0;
                tx_q   <= rd_byte;
                sda_oe <= !rd_byte[DATA_W-1];
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: SDA is left to the controller during its acknowledge slot
  assert_rack_released_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK) |-> !sda_oe);
  // R10: a START always begins a fresh address phase
  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && start_det) |=> (state == ST_ADDR && !sda_oe));
  // R9: a foreign address drops the target to idle without an ACK
  assert_foreign_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && state == ST_ADDR && scl_fall && byte_full && !start_det
     && !stop_det && !addr_hit) |=> (state == ST_IDLE && !sda_oe));
  // R11: transmit byte only moves on SCL falling edges
  assert_tx_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && state == ST_RDATA && !scl_fall) |=> $stable(tx_q));
endmodule

// File: rtl/lnbc_i2c_target.sv
module lnbc_i2c_target #(
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W       = 6,
  parameter int FLT_W       = 2,
  parameter logic [6:0] ADDR_BASE = 7'b0001000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic addr_sel_i,
  input  logic pwr_good_i,
  input  logic fault_temp_i,
  input  logic fault_ovl_i,
  output logic cur_lim_mode_o,
  output logic cur_sel_o,
  output logic tone_en_o,
  output logic line_comp_o,
  output logic volt_sel_o,
  output logic pwr_en_o
);
  localparam int REG_W = CTL_W + FLT_W;

  logic [1:0]       bus_s;
  logic [FLT_W-1:0] flt_s;
  logic [CTL_W-1:0] ctl_q;
  logic [REG_W-1:0] rd_byte, wr_byte;
  logic             wr_en;

  lnbc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_bus_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );

  lnbc_sync #(.WIDTH(FLT_W), .STAGES(SYNC_STAGES), .INIT('0)) u_flt_sync (
    .clk(clk), .rst(rst), .d({fault_temp_i, fault_ovl_i}), .q(flt_s)
  );

  lnbc_bus_fsm #(.ADDR_W(7), .DATA_W(REG_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
    .clk(clk), .rst(rst), .pwr_good(pwr_good_i),
    .scl_s(bus_s[1]), .sda_s(bus_s[0]), .addr_sel(addr_sel_i),
    .rd_byte(rd_byte), .wr_en(wr_en), .wr_byte(wr_byte), .sda_oe(sda_oe_o)
  );

  lnbc_ctrl_reg #(.CTL_W(CTL_W), .FLT_W(FLT_W)) u_reg (
    .clk(clk), .rst(rst), .pwr_good(pwr_good_i), .wr_en(wr_en),
    .wr_data(wr_byte), .flt_s(flt_s), .ctl_q(ctl_q), .rd_byte(rd_byte)
  );

  assign cur_lim_mode_o = ctl_q[CTL_W-1];
  assign cur_sel_o      = ctl_q[CTL_W-2];
  assign tone_en_o      = ctl_q[CTL_W-3];
  assign line_comp_o    = ctl_q[CTL_W-4];
  assign volt_sel_o     = ctl_q[CTL_W-5];
  assign pwr_en_o       = ctl_q[CTL_W-6];

  // R7: nothing is driven and power stays off while unpowered
  assert_silent_unpowered_R7: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (!sda_oe_o && !pwr_en_o));
endmodule

// File: tb/lnbc_i2c_target_tb_top.sv
module lnbc_i2c_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 12;
  localparam logic [6:0] A0 = 7'b0001000;
  localparam logic [6:0] A1 = 7'b0001001;

  logic clk = 0, rst = 1;
  logic ctl_scl = 1, ctl_sda = 1;
  logic addr_sel = 0, pg = 1, f_temp = 0, f_ovl = 0;
  logic sda_oe, o7, o6, o5, o4, o3, o2;
  logic sda_line;
  int   checks = 0, failures = 0, oe_bad = 0;
  bit   done = 0;

  assign sda_line = ctl_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  lnbc_i2c_target dut_i (
    .clk(clk), .rst(rst), .scl_i(ctl_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pwr_good_i(pg), .fault_temp_i(f_temp), .fault_ovl_i(f_ovl),
    .cur_lim_mode_o(o7), .cur_sel_o(o6), .tone_en_o(o5), .line_comp_o(o4),
    .volt_sel_o(o3), .pwr_en_o(o2)
  );

  always @(negedge clk) if (!pg && sda_oe) oe_bad++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q; repeat (QTR) @(negedge clk); endtask
  task automatic bus_start; ctl_sda = 1; q; ctl_scl = 1; q; ctl_sda = 0; q; ctl_scl = 0; q; endtask
  task automatic bus_stop; ctl_sda = 0; q; ctl_scl = 1; q; ctl_sda = 1; q; q; endtask
  task automatic send_bit(input logic b); ctl_sda = b; q; ctl_scl = 1; q; q; ctl_scl = 0; q; endtask
  task automatic get_bit(output logic b); ctl_sda = 1; q; ctl_scl = 1; q; b = sda_line; q; ctl_scl = 0; q; endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(nak);
    ack = !nak;
  endtask

  task automatic get_byte(output logic [7:0] d, input int flip_at);
    for (int i = 7; i >= 0; i--) begin
      if (i == flip_at) f_temp = ~f_temp;
      get_bit(d[i]);
    end
  endtask

  function automatic logic [5:0] outs(); return {o7, o6, o5, o4, o3, o2}; endfunction

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, output logic aa, output logic da);
    bus_start; send_byte({a, 1'b0}, aa); send_byte(d, da); bus_stop;
  endtask

  task automatic t_reset;
    chk("R12", "outputs after reset", outs(), 6'h00);
    chk("R12", "sda_oe after reset", sda_oe, 1'b0);
  endtask

  task automatic t_write_read;
    logic aa, da; logic [7:0] b0, b1;
    do_write(A0, 8'b1010_1111, aa, da);
    chk("R1", "ack of addr 0x08 with sel=0", aa, 1'b1);
    chk("R2", "data ack", da, 1'b1);
    chk("R2", "control outputs", outs(), 6'b101011);
    bus_start; send_byte({A0, 1'b1}, aa);
    get_byte(b0, -1); send_bit(1'b0);
    get_byte(b1, -1); send_bit(1'b1);
    q; chk("R4", "sda released after NACK", sda_oe, 1'b0);
    bus_stop;
    chk("R3", "read ack", aa, 1'b1);
    chk("R5", "first byte bits 7..2", b0[7:2], 6'b101011);
    chk("R6", "written low bits ignored", b0[1:0], 2'b00);
    chk("R4", "second byte after ACK", b1, {6'b101011, 2'b00});
  endtask

  task automatic t_faults;
    logic aa; logic [7:0] b;
    f_temp = 1; f_ovl = 0; q;
    bus_start; send_byte({A0, 1'b1}, aa); get_byte(b, -1); send_bit(1'b1); bus_stop;
    chk("R6", "temp fault on bit 1", b, {6'b101011, 2'b10});
    f_temp = 0; f_ovl = 1; q;
    bus_start; send_byte({A0, 1'b1}, aa); get_byte(b, -1); send_bit(1'b1); bus_stop;
    chk("R6", "overload fault on bit 0", b, {6'b101011, 2'b01});
    f_ovl = 0; q;
  endtask

  task automatic t_midbyte;
    logic aa; logic [7:0] b0, b1;
    bus_start; send_byte({A0, 1'b1}, aa);
    get_byte(b0, 3); send_bit(1'b0);
    get_byte(b1, -1); send_bit(1'b1); bus_stop;
    chk("R11", "fault change mid-byte hidden", b0[1:0], 2'b00);
    chk("R11", "fault seen in next byte", b1[1:0], 2'b10);
    f_temp = 0; q;
  endtask

  task automatic t_nomatch;
    logic aa, da; logic [7:0] b;
    bus_start; send_byte({A1, 1'b0}, aa); send_byte(8'h00, da); bus_stop;
    chk("R9", "foreign address NACK", aa, 1'b0);
    chk("R9", "following data ignored", {da, outs()}, {1'b0, 6'b101011});
    addr_sel = 1; q;
    do_write(A0, 8'h00, aa, da);
    chk("R1", "0x08 refused with sel=1", {aa, outs()}, {1'b0, 6'b101011});
    do_write(A1, 8'b0101_0100, aa, da);
    chk("R1", "0x09 accepted with sel=1", {aa, da, outs()}, {2'b11, 6'b010101});
    bus_start; send_byte({A1, 1'b1}, aa); get_byte(b, -1); send_bit(1'b1); bus_stop;
    chk("R1", "read via 0x09", b, 8'b0101_0100);
  endtask

  task automatic t_abort;
    logic aa, da; logic [7:0] b;
    bus_start; send_byte({A1, 1'b0}, aa);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    chk("R10", "STOP mid-byte discards data", outs(), 6'b010101);
    bus_start; send_byte({A1, 1'b0}, aa);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start; send_byte({A1, 1'b1}, aa); get_byte(b, -1); send_bit(1'b1); bus_stop;
    chk("R10", "repeated START begins new read", {aa, b}, {1'b1, 8'b0101_0100});
  endtask

  task automatic t_power;
    logic aa, da;
    pg = 0; q;
    chk("R7", "outputs cleared when unpowered", outs(), 6'h00);
    do_write(A1, 8'hFC, aa, da);
    chk("R7", "no ack while unpowered", {aa, da}, 2'b00);
    chk("R7", "outputs still zero", outs(), 6'h00);
    chk("R7", "sda never driven unpowered", oe_bad, 0);
    pg = 1; q;
    do_write(A1, 8'b0000_0100, aa, da);
    chk("R8", "write after power-good", {aa, da, o2}, 3'b111);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    t_reset;
    t_write_read;
    t_faults;
    t_midbyte;
    t_nomatch;
    t_abort;
    t_power;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule